// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block turns a fast reference clock into a slow core clock whose long-run average frequency falls between two neighbouring integer divide ratios. It runs a run of periods with a first divisor, then a run with a second divisor, and repeats that pair of runs. Each run length is programmable on its own, so the average ratio can be tuned finely. The main use is to make an accurate 32.768 kHz tick from a 24 MHz crystal. Dividing by 733 for 8 periods and then by 732 for 11 periods gives 13916 reference cycles per 19 output periods, which averages about 32768 Hz.

Every numeric field holds the wanted value minus one. A small sequencer state machine picks the divisor for each output period. Its states are `SEQ_HOLD` (input gate closed, all counters at zero), `SEQ_PHASE_A` (first divisor) and `SEQ_PHASE_B` (second divisor). It has these transitions:
- HOLD→A when the input gate opens.
- A→A at a period end while the A run is unfinished or dual mode is off.
- A→B at the end of the last A period in dual mode.
- B→B at a period end while the B run is unfinished.
- B→A at the end of the last B period, or at any B period end with dual mode off.
- any→HOLD when the input gate closes.

A pass-through mode sends the reference straight to the output. A separate output gate forces the output low.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is asserted, and after reset with both gates closed, `clk_out` is low.
- R2: A divisor field value k (k ≥ 1) gives output periods of exactly k+1 reference cycles.
- R3: Each divide-by-N period is high for floor(N/2) reference cycles and low for the remaining N − floor(N/2), including odd N.
- R4: With dual mode on, the output runs `cfg_rep_a`+1 periods of divisor A, then `cfg_rep_b`+1 periods of divisor B, and repeats.
- R5: With dual mode off, every period uses divisor A, and the divisor B and repeat fields have no effect.
- R6: Over one full dual cycle, the total number of reference cycles equals (rep_a+1)(div_a+1) + (rep_b+1)(div_b+1).
- R7: With pass-through on and both gates open, `clk_out` equals the reference clock whatever the divisor fields hold. With the input gate closed it is low.
- R8: While `cfg_in_en` is low, the output is low and all counters stay at zero. Reopening the gate always begins with a full divisor-A period.
- R9: While `cfg_out_en` is low, `clk_out` is low.
- R10: Configuration is taken only at output-period boundaries. A divisor change made mid-period leaves the current period at its old length.
- R11: The setting div 732/731 with repeats 7/10 yields 13916 reference cycles per 19 output periods, with a 366-cycle high phase in a 733 period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div_a | input | DIV_W | First divisor minus one |
| cfg_div_b | input | DIV_W | Second divisor minus one |
| cfg_rep_a | input | REP_W | Periods per divisor-A run, minus one |
| cfg_rep_b | input | REP_W | Periods per divisor-B run, minus one |
| cfg_dual_en | input | 1 | Alternate between both divisors |
| cfg_bypass | input | 1 | Pass the reference straight through |
| cfg_in_en | input | 1 | Input gate; low holds the divider at zero |
| cfg_out_en | input | 1 | Output gate; low forces the output low |
| clk_out | output | 1 | Divided (or passed-through) clock |

## Verification
A wrong period counter shows up within one output period, as a high or low phase of the wrong length. A sequencer that mis-counts a run or skips a state makes some period in the dual cycle take the other divisor's length. It also shifts the cycle total, so it is seen within one full cycle of A and B runs. A mishandled gate or a mid-period configuration load shows up in the very next period measured after that stimulus. The sweeps cover every small pair of divisors and repeat counts, so an off-by-one in any compare is visible.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [1:0] {
        SEQ_HOLD    = 2'd0,
        SEQ_PHASE_A = 2'd1,
        SEQ_PHASE_B = 2'd2
    } seq_state_e;
endpackage

// File: rtl/fcd_period_gen.sv
// Counts reference cycles within one output period and forms its high phase.
module fcd_period_gen #(
    parameter int DIV_W = 10
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             load,
    input  logic [DIV_W-1:0] div_next,
    output logic             period_end,
    output logic             hi,
    output logic [DIV_W-1:0] cnt,
    output logic [DIV_W-1:0] cur_div
);
    localparam int HW = DIV_W + 1;

    logic [HW-1:0] half_next;
    logic [HW-1:0] half_cur;
    logic [HW-1:0] cnt_inc;

    // floor((k+1)/2) = high length for a field value k
    assign half_next  = ({1'b0, div_next} + HW'(1)) >> 1;
    assign half_cur   = ({1'b0, cur_div}  + HW'(1)) >> 1;
    assign cnt_inc    = {1'b0, cnt} + HW'(1);
    assign period_end = run && (cnt == cur_div);

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur_div <= '0;
            hi      <= 1'b0;
        end else if (clr) begin
            cnt     <= '0;
            cur_div <= '0;
            hi      <= 1'b0;
        end else if (load || period_end) begin
            cnt     <= '0;
            cur_div <= div_next;
            hi      <= (half_next != '0);
        end else if (run) begin
            cnt     <= cnt_inc[DIV_W-1:0];
            hi      <= (cnt_inc < half_cur);
        end
    end
endmodule

// File: rtl/fcd_seq.sv
// Alternation sequencer: picks the divisor for each output period.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int REP_W = 4
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic             dual_en,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    input  logic [REP_W-1:0] rep_a,
    input  logic [REP_W-1:0] rep_b,
    input  logic             period_end,
    output seq_state_e       state,
    output logic             load,
    output logic             run,
    output logic             clr,
    output logic [DIV_W-1:0] div_next
);
    seq_state_e       state_nxt;
    logic [REP_W-1:0] rcnt, rcnt_nxt;

    // state register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_HOLD;
            rcnt  <= '0;
        end else begin
            state <= state_nxt;
            rcnt  <= rcnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        rcnt_nxt  = rcnt;
        unique case (state)
            SEQ_HOLD: begin
                if (in_en) begin
                    state_nxt = SEQ_PHASE_A;
                    rcnt_nxt  = '0;
                end
            end
            SEQ_PHASE_A: begin
                if (period_end) begin
                    if (!dual_en) begin
                        rcnt_nxt = '0;
                    end else if (rcnt == rep_a) begin
                        state_nxt = SEQ_PHASE_B;
                        rcnt_nxt  = '0;
                    end else begin
                        rcnt_nxt = rcnt + REP_W'(1);
                    end
                end
            end
            SEQ_PHASE_B: begin
                if (period_end) begin
                    if (!dual_en || (rcnt == rep_b)) begin
                        state_nxt = SEQ_PHASE_A;
                        rcnt_nxt  = '0;
                    end else begin
                        rcnt_nxt = rcnt + REP_W'(1);
                    end
                end
            end
            default: begin
                state_nxt = SEQ_HOLD;
                rcnt_nxt  = '0;
            end
        endcase
        if (!in_en) begin
            state_nxt = SEQ_HOLD;
            rcnt_nxt  = '0;
        end
    end

    // outputs
    always_comb begin
        load     = (state == SEQ_HOLD) && in_en;
        run      = (state != SEQ_HOLD);
        clr      = !in_en;
        div_next = (state_nxt == SEQ_PHASE_B) ? div_b : div_a;
    end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fcd_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int REP_W = 4
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div_a,
    input  logic [DIV_W-1:0] cfg_div_b,
    input  logic [REP_W-1:0] cfg_rep_a,
    input  logic [REP_W-1:0] cfg_rep_b,
    input  logic             cfg_dual_en,
    input  logic             cfg_bypass,
    input  logic             cfg_in_en,
    input  logic             cfg_out_en,
    output logic             clk_out
);
    seq_state_e       state;
    logic             load, run, clr, period_end, div_hi;
    logic [DIV_W-1:0] div_next, cnt, cur_div;

    fcd_seq #(.DIV_W(DIV_W), .REP_W(REP_W)) u_seq (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .in_en      (cfg_in_en),
        .dual_en    (cfg_dual_en),
        .div_a      (cfg_div_a),
        .div_b      (cfg_div_b),
        .rep_a      (cfg_rep_a),
        .rep_b      (cfg_rep_b),
        .period_end (period_end),
        .state      (state),
        .load       (load),
        .run        (run),
        .clr        (clr),
        .div_next   (div_next)
    );

    fcd_period_gen #(.DIV_W(DIV_W)) u_pgen (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .clr        (clr),
        .run        (run),
        .load       (load),
        .div_next   (div_next),
        .period_end (period_end),
        .hi         (div_hi),
        .cnt        (cnt),
        .cur_div    (cur_div)
    );

    // pass-through and gating
    assign clk_out = cfg_out_en & (cfg_bypass ? (clk_ref & cfg_in_en) : div_hi);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic             cfg_in_en,
    input logic             cfg_out_en,
    input logic             cfg_dual_en,
    input logic             clk_out,
    input logic             div_hi,
    input seq_state_e       state,
    input logic             period_end,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] cur_div
);
    p_hold_low_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !cfg_in_en |=> (!div_hi && cnt == '0))
        else $error("R8 gate closed but divider active");

    p_start_a_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state == SEQ_HOLD && cfg_in_en) |=> (state == SEQ_PHASE_A && cnt == '0))
        else $error("R8 restart not in phase A");

    p_cnt_bound_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state != SEQ_HOLD) |-> (cnt <= cur_div))
        else $error("R2 counter past divisor");

    p_div_stable_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state != SEQ_HOLD && !period_end && cfg_in_en) |=> $stable(cur_div))
        else $error("R10 divisor changed mid-period");

    p_single_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!cfg_dual_en && period_end && cfg_in_en) |=> (state == SEQ_PHASE_A))
        else $error("R5 left phase A in single mode");

    always_comb begin
        if (!cfg_out_en) begin
            p_oen_gate_r9: assert (clk_out == 1'b0)
                else $error("R9 output not gated");
        end
    end
endmodule

bind frac_clk_div fcd_checker #(.DIV_W(DIV_W)) u_fcd_chk (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .cfg_in_en   (cfg_in_en),
    .cfg_out_en  (cfg_out_en),
    .cfg_dual_en (cfg_dual_en),
    .clk_out     (clk_out),
    .div_hi      (div_hi),
    .state       (state),
    .period_end  (period_end),
    .cnt         (cnt),
    .cur_div     (cur_div)
);

// File: tb/frac_clk_div_bench.sv
`timescale 1ns/1ps
module frac_clk_div_bench;
    localparam int DIV_W = 10;
    localparam int REP_W = 4;

    logic             clk_ref = 1'b0;
    logic             rst_n   = 1'b0;
    logic [DIV_W-1:0] cfg_div_a = '0, cfg_div_b = '0;
    logic [REP_W-1:0] cfg_rep_a = '0, cfg_rep_b = '0;
    logic             cfg_dual_en = 1'b0, cfg_bypass = 1'b0;
    logic             cfg_in_en = 1'b0, cfg_out_en = 1'b0;
    logic             clk_out;

    int  vectors = 0;
    int  miscompares = 0;
    int  cyc = 0;
    logic cur = 1'b0;

    always #2.5 clk_ref = ~clk_ref;

    frac_clk_div #(.DIV_W(DIV_W), .REP_W(REP_W)) u_frac_clk_div (
        .clk_ref(clk_ref), .rst_n(rst_n),
        .cfg_div_a(cfg_div_a), .cfg_div_b(cfg_div_b),
        .cfg_rep_a(cfg_rep_a), .cfg_rep_b(cfg_rep_b),
        .cfg_dual_en(cfg_dual_en), .cfg_bypass(cfg_bypass),
        .cfg_in_en(cfg_in_en), .cfg_out_en(cfg_out_en),
        .clk_out(clk_out)
    );

    always @(posedge clk_ref) begin
        cyc++;
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<=150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk_ref);
        cur = clk_out;
    endtask

    task automatic measure(output int h, output int l);
        h = 0;
        l = 0;
        while (cur == 1'b1 && h < 4000) begin h++; step(); end
        while (cur == 1'b0 && l < 4000) begin l++; step(); end
    endtask

    // closes gates, programs, reopens at a falling edge
    task automatic program_cfg(input int da, input int db, input int ra, input int rb,
                               input bit dual);
        @(negedge clk_ref);
        cfg_in_en  = 1'b0;
        cfg_out_en = 1'b0;
        step();
        step();
        cfg_div_a   = DIV_W'(da);
        cfg_div_b   = DIV_W'(db);
        cfg_rep_a   = REP_W'(ra);
        cfg_rep_b   = REP_W'(rb);
        cfg_dual_en = dual;
        cfg_bypass  = 1'b0;
        cfg_in_en   = 1'b1;
        cfg_out_en  = 1'b1;
        step();
    endtask

    task automatic run_cfg(input int da, input int db, input int ra, input int rb,
                           input bit dual, input int nper, output int super_sum);
        int superlen;
        program_cfg(da, db, ra, rb, dual);
        superlen  = dual ? (ra + rb + 2) : 1;
        super_sum = 0;
        for (int p = 0; p < nper; p++) begin
            int h, l, n, pos;
            pos = p % superlen;
            n = (!dual || pos <= ra) ? da + 1 : db + 1;
            measure(h, l);
            if (dual) chk("R4 period length", h + l, n);
            else      chk("R5 period length", h + l, n);
            chk("R2 period length", h + l, n);
            chk("R3 high phase", h, n / 2);
            if (p < superlen) super_sum += h + l;
        end
        if (dual) chk("R6 super-period total", super_sum,
                      (ra + 1) * (da + 1) + (rb + 1) * (db + 1));
    endtask

    initial begin
        int s, h, l;
        // R1: reset state
        #1;
        chk("R1 output in reset", int'(clk_out), 0);
        repeat (3) @(negedge clk_ref);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R1 output after reset, gates closed", int'(cur), 0);
        end

        // R4/R6: dual sweep over small divisors and repeats
        for (int da = 1; da <= 5; da++)
            for (int db = 1; db <= 5; db++)
                for (int ra = 0; ra <= 2; ra++)
                    for (int rb = 0; rb <= 2; rb++)
                        run_cfg(da, db, ra, rb, 1'b1, 2 * (ra + rb + 2), s);

        // R5: single mode, B fields differ and are ignored
        for (int da = 1; da <= 9; da++)
            run_cfg(da, 6, 1, 3, 1'b0, 4, s);

        // R10: divisor change mid-period
        program_cfg(7, 2, 0, 0, 1'b0);
        cfg_div_a = DIV_W'(3);
        measure(h, l);
        chk("R10 current period keeps old length", h + l, 8);
        measure(h, l);
        chk("R10 next period uses new length", h + l, 4);
        chk("R10 next period high", h, 2);

        // R8: close input gate during phase B, then restart
        program_cfg(2, 4, 1, 1, 1'b1);
        for (int p = 0; p < 3; p++) measure(h, l);
        cfg_in_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R8 output low while gate closed", int'(cur), 0);
        end
        cfg_in_en = 1'b1;
        step();
        measure(h, l);
        chk("R8 restart with phase A length", h + l, 3);
        measure(h, l);
        chk("R8 second A period", h + l, 3);
        measure(h, l);
        chk("R8 then phase B", h + l, 5);

        // R9: output gate closed while dividing
        cfg_out_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk_ref); #1;
            chk("R9 output gated (clock high)", int'(clk_out), 0);
            @(negedge clk_ref); #1;
            chk("R9 output gated (clock low)", int'(clk_out), 0);
        end

        // R7: pass-through
        cfg_out_en = 1'b1;
        cfg_bypass = 1'b1;
        cfg_div_a  = DIV_W'(5);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_ref); #1;
            chk("R7 pass-through high", int'(clk_out), 1);
            @(negedge clk_ref); #1;
            chk("R7 pass-through low", int'(clk_out), 0);
        end
        cfg_in_en = 1'b0;
        @(posedge clk_ref); #1;
        chk("R7 pass-through with input gate closed", int'(clk_out), 0);
        cfg_bypass = 1'b0;

        // R11: intended 24 MHz to 32.768 kHz setting
        run_cfg(732, 731, 7, 10, 1'b1, 19, s);
        chk("R11 reference cycles per 19 periods", s, 13916);
        program_cfg(732, 731, 7, 10, 1'b1);
        measure(h, l);
        chk("R11 high phase of 733 period", h, 366);
        chk("R11 low phase of 733 period", l, 367);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule